// File: doc/BRIEF.md
# Programmable Almost-Flag Offset Unit

This unit sits beside the storage of a two-clock FIFO. It keeps two threshold registers: one sets how close to empty the almost-empty flag turns on, and the other sets how close to full the almost-full flag turns on. It compares each threshold with the occupancy count of its own clock domain and drives the two flags from registers.

The level of the load pin during master reset makes two choices at once. It picks the default threshold for both flags, and it picks how the thresholds are reprogrammed afterwards. Reprogramming is either bit by bit from a serial input or nine bits at a time from the write data bus, both clocked by the write clock. Software can read the thresholds back nine bits at a time on the read data bus, clocked by the read clock, whichever load method is in force.

A partial reset returns the piece pointers to their start and keeps the thresholds and the load method. A full reprogramming is therefore never needed after a mid-operation restart.

Top module: `almost_flag_unit`

## Requirements
- R1: A master reset (mrst_n low on a clock edge) sampled while ld is low sets both thresholds to 127 and selects parallel loading.
- R2: A master reset sampled while ld is high sets both thresholds to 1023 and selects serial loading.
- R3: In parallel mode, each write-clock edge with wen and ld both high stores din into one 9-bit piece. The pieces go in this order: sequence slot 0 is empty threshold bits 8:0, slot 1 is empty threshold bits 16:9, slot 2 is full threshold bits 8:0, slot 3 is full threshold bits 16:9. Piece bits that lie above bit 16 are discarded. After slot 3 the sequence returns to slot 0.
- R4: A write-clock edge without both ld and wen high does not change a threshold. A parallel write made in serial mode is ignored and does not advance the sequence.
- R5: In serial mode, each write-clock edge with sen and ld both high takes si into the next threshold bit. The order is empty threshold bit 0 up to bit 16, then full threshold bit 0 up to bit 16. Bits that arrive after those 34 are ignored. Serial bits sent in parallel mode are ignored.
- R6: On a read-clock edge with ren and ld both high, dout takes the next piece, using the same slot order and wrap as R3, with bits above the threshold width read as zero. This works in both modes. On any other read-clock edge, dout holds its value.
- R7: A partial reset (prst_n low) returns the write sequence, the serial bit position and the readback sequence to their start. It keeps both thresholds and the load method.
- R8: On each read-clock edge, almost_empty takes the value (rd_occ <= empty threshold).
- R9: On each write-clock edge, almost_full takes the value ((2^17 - wr_occ) <= full threshold).
- R10: Either reset drives almost_empty high, almost_full low and dout to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-domain clock |
| rclk | input | 1 | Read-domain clock |
| mrst_n | input | 1 | Master reset, synchronous, active low, sampled in both domains |
| prst_n | input | 1 | Partial reset, synchronous, active low, sampled in both domains |
| ld | input | 1 | Load select; picks defaults and mode during master reset, qualifies load and readback otherwise |
| wen | input | 1 | Write enable for parallel threshold loading |
| sen | input | 1 | Serial enable for bit-wise threshold loading |
| si | input | 1 | Serial threshold data bit |
| din | input | 9 | Parallel threshold piece |
| ren | input | 1 | Read enable for threshold readback |
| rd_occ | input | 18 | FIFO occupancy seen in the read domain |
| wr_occ | input | 18 | FIFO occupancy seen in the write domain |
| dout | output | 9 | Readback piece |
| almost_empty | output | 1 | Occupancy at or below the empty threshold |
| almost_full | output | 1 | Free space at or below the full threshold |

## Verification
Every cycle, the assertions check that each flag follows its comparison one edge later. They also check that the thresholds stay unchanged on edges with no qualified load and across a partial reset, that dout holds when no readback is requested, and that the parallel sequence wraps from its last slot to the first. The other behaviours are checked by the bench scenarios, with the thresholds read back only through dout: the defaults chosen at master reset, the piece and bit ordering, the discarded upper bits, serial bits ignored past the 34th, and pointers cleared by a partial reset part way through a sequence.

// File: rtl/afu_pkg.sv
// Package: shared constants, the load-method type and helper functions
// for the almost-flag offset unit.
package afu_pkg;

    // How thresholds are reprogrammed after master reset
    typedef enum logic {
        LOAD_PARALLEL = 1'b0,
        LOAD_SERIAL   = 1'b1
    } load_mode_e;

    // Default thresholds chosen by the load pin at master reset
    localparam int DEF_OFFSET_LOW_PIN  = 127;
    localparam int DEF_OFFSET_HIGH_PIN = 1023;

    // Number of bus-width pieces needed to carry one threshold
    function automatic int pieces_per_offset(input int addr_w, input int piece_w);
        return (addr_w + piece_w - 1) / piece_w;
    endfunction

    // Bits needed to hold values 0..n-1 (at least one)
    function automatic int idx_width(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/afu_offset_regs.sv
// Module: afu_offset_regs
// Holds the empty-side and full-side thresholds in the write clock domain.
// It latches the load method and the defaults at master reset, then updates
// the thresholds from parallel pieces or serial bits, depending on the mode.
// Assumes: synchronous active-low resets; a master reset takes priority over
// a partial reset; the piece width is at most the threshold width.
module afu_offset_regs
    import afu_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int PIECE_W = 9
) (
    input  logic                 wclk,
    input  logic                 mrst_n,
    input  logic                 prst_n,
    input  logic                 ld,
    input  logic                 wen,
    input  logic                 sen,
    input  logic                 si,
    input  logic [PIECE_W-1:0]   din,
    output logic [ADDR_W-1:0]    empty_thr,
    output logic [ADDR_W-1:0]    full_thr,
    output logic                 serial_mode,
    output logic [idx_width(2*pieces_per_offset(ADDR_W, PIECE_W))-1:0] wseq
);

    localparam int NPC      = pieces_per_offset(ADDR_W, PIECE_W);
    localparam int PAD_W    = NPC * PIECE_W;
    localparam int NSEQ     = 2 * NPC;
    localparam int SEQ_W    = idx_width(NSEQ);
    localparam int SER_BITS = 2 * ADDR_W;
    localparam int SCNT_W   = $clog2(SER_BITS + 1);

    load_mode_e            mode_q;
    logic [SCNT_W-1:0]     sbit_q;
    logic [ADDR_W-1:0]     thr_q   [2];
    logic [ADDR_W-1:0]     thr_nxt [2];
    logic                  par_go;
    logic                  ser_go;
    logic                  any_rst;

    assign par_go  = ld && wen && (mode_q == LOAD_PARALLEL);
    assign ser_go  = ld && sen && (mode_q == LOAD_SERIAL) && (sbit_q < SCNT_W'(SER_BITS));
    assign any_rst = !mrst_n || !prst_n;

    // Latch the load method while master reset is held
    always_ff @(posedge wclk) begin
        if (!mrst_n) mode_q <= ld ? LOAD_SERIAL : LOAD_PARALLEL;
    end

    // Advance the parallel piece pointer, wrapping after the last slot
    always_ff @(posedge wclk) begin
        if (any_rst)                          wseq <= '0;
        else if (par_go && wseq == SEQ_W'(NSEQ - 1)) wseq <= '0;
        else if (par_go)                      wseq <= wseq + SEQ_W'(1);
    end

    // Count serial bits taken, stopping once both thresholds are filled
    always_ff @(posedge wclk) begin
        if (any_rst)     sbit_q <= '0;
        else if (ser_go) sbit_q <= sbit_q + SCNT_W'(1);
    end

    for (genvar g = 0; g < 2; g++) begin : g_thr
        // Merge a parallel piece or a serial bit into this threshold
        always_comb begin
            logic [PAD_W-1:0] padded;
            padded = PAD_W'(thr_q[g]);
            for (int k = 0; k < NPC; k++) begin
                if (par_go && wseq == SEQ_W'(g * NPC + k))
                    padded[k*PIECE_W +: PIECE_W] = din;
            end
            for (int b = 0; b < ADDR_W; b++) begin
                if (ser_go && sbit_q == SCNT_W'(g * ADDR_W + b))
                    padded[b] = si;
            end
            thr_nxt[g] = padded[ADDR_W-1:0];
        end

        // Hold the threshold; load the default under master reset only
        always_ff @(posedge wclk) begin
            if (!mrst_n) thr_q[g] <= ld ? ADDR_W'(DEF_OFFSET_HIGH_PIN) : ADDR_W'(DEF_OFFSET_LOW_PIN);
            else         thr_q[g] <= thr_nxt[g];
        end
    end

    assign empty_thr   = thr_q[0];
    assign full_thr    = thr_q[1];
    assign serial_mode = (mode_q == LOAD_SERIAL);

endmodule

// File: rtl/afu_readback.sv
// Module: afu_readback
// Returns the thresholds on the output bus one piece per qualified
// read-clock edge, in the same slot order the parallel loader uses.
// Assumes: the thresholds are not being reloaded while a readback is in
// progress, so they are read as stable values across the clock domains.
module afu_readback
    import afu_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int PIECE_W = 9
) (
    input  logic                 rclk,
    input  logic                 mrst_n,
    input  logic                 prst_n,
    input  logic                 ld,
    input  logic                 ren,
    input  logic [ADDR_W-1:0]    empty_thr,
    input  logic [ADDR_W-1:0]    full_thr,
    output logic [PIECE_W-1:0]   dout
);

    localparam int NPC   = pieces_per_offset(ADDR_W, PIECE_W);
    localparam int PAD_W = NPC * PIECE_W;
    localparam int NSEQ  = 2 * NPC;
    localparam int SEQ_W = idx_width(NSEQ);

    logic [SEQ_W-1:0]   rseq_q;
    logic [PAD_W-1:0]   padded [2];
    logic [PIECE_W-1:0] piece_sel;
    logic               rd_go;

    assign rd_go     = ld && ren;
    assign padded[0] = PAD_W'(empty_thr);
    assign padded[1] = PAD_W'(full_thr);

    // Select the piece the readback pointer names
    always_comb begin
        piece_sel = '0;
        for (int i = 0; i < NSEQ; i++) begin
            if (rseq_q == SEQ_W'(i))
                piece_sel = padded[i / NPC][(i % NPC)*PIECE_W +: PIECE_W];
        end
    end

    // Step the readback pointer with wrap; cleared by either reset
    always_ff @(posedge rclk) begin
        if (!mrst_n || !prst_n)                        rseq_q <= '0;
        else if (rd_go && rseq_q == SEQ_W'(NSEQ - 1))  rseq_q <= '0;
        else if (rd_go)                                rseq_q <= rseq_q + SEQ_W'(1);
    end

    // Register the selected piece onto the output bus
    always_ff @(posedge rclk) begin
        if (!mrst_n || !prst_n) dout <= '0;
        else if (rd_go)         dout <= piece_sel;
    end

endmodule

// File: rtl/afu_flag_cmp.sv
// Module: afu_flag_cmp
// Registered "at or below" comparator used for both almost flags.
// Assumes: lhs and threshold are unsigned; the threshold is zero-extended.
module afu_flag_cmp #(
    parameter int  LHS_W   = 18,
    parameter int  THR_W   = 17,
    parameter bit  RST_VAL = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LHS_W-1:0]  lhs,
    input  logic [THR_W-1:0]  thr,
    output logic              flag
);

    localparam int CMP_W = (LHS_W > THR_W) ? LHS_W : THR_W;

    logic hit;

    assign hit = CMP_W'(lhs) <= CMP_W'(thr);

    // Register the comparison result in this clock domain
    always_ff @(posedge clk) begin
        if (!rst_n) flag <= RST_VAL;
        else        flag <= hit;
    end

endmodule

// File: rtl/almost_flag_unit.sv
// Module: almost_flag_unit (top)
// Programmable almost-empty / almost-full threshold unit for a two-clock
// FIFO. Thresholds live in the write domain. Readback and the almost-empty
// flag run in the read domain, and the almost-full flag runs in the write
// domain.
// Assumes: occupancy inputs are already valid in their own domains, and
// thresholds are reprogrammed only while the read side is not using them.
module almost_flag_unit
    import afu_pkg::*;
#(
    parameter int ADDR_W  = 17,
    parameter int PIECE_W = 9
) (
    input  logic                 wclk,
    input  logic                 rclk,
    input  logic                 mrst_n,
    input  logic                 prst_n,
    input  logic                 ld,
    input  logic                 wen,
    input  logic                 sen,
    input  logic                 si,
    input  logic [PIECE_W-1:0]   din,
    input  logic                 ren,
    input  logic [ADDR_W:0]      rd_occ,
    input  logic [ADDR_W:0]      wr_occ,
    output logic [PIECE_W-1:0]   dout,
    output logic                 almost_empty,
    output logic                 almost_full
);

    localparam int OCC_W = ADDR_W + 1;
    localparam int NPC   = pieces_per_offset(ADDR_W, PIECE_W);
    localparam int SEQ_W = idx_width(2 * NPC);
    localparam logic [OCC_W-1:0] DEPTH_V = OCC_W'(1) << ADDR_W;

    logic [ADDR_W-1:0] empty_thr;
    logic [ADDR_W-1:0] full_thr;
    logic              serial_mode;
    logic [SEQ_W-1:0]  wseq;
    logic [OCC_W-1:0]  free_space;
    logic              flags_rst_n;

    assign flags_rst_n = mrst_n && prst_n;
    assign free_space  = DEPTH_V - wr_occ;

    afu_offset_regs #(.ADDR_W(ADDR_W), .PIECE_W(PIECE_W)) u_regs (
        .wclk        (wclk),
        .mrst_n      (mrst_n),
        .prst_n      (prst_n),
        .ld          (ld),
        .wen         (wen),
        .sen         (sen),
        .si          (si),
        .din         (din),
        .empty_thr   (empty_thr),
        .full_thr    (full_thr),
        .serial_mode (serial_mode),
        .wseq        (wseq)
    );

    afu_readback #(.ADDR_W(ADDR_W), .PIECE_W(PIECE_W)) u_rdbk (
        .rclk      (rclk),
        .mrst_n    (mrst_n),
        .prst_n    (prst_n),
        .ld        (ld),
        .ren       (ren),
        .empty_thr (empty_thr),
        .full_thr  (full_thr),
        .dout      (dout)
    );

    afu_flag_cmp #(.LHS_W(OCC_W), .THR_W(ADDR_W), .RST_VAL(1'b1)) u_ae (
        .clk   (rclk),
        .rst_n (flags_rst_n),
        .lhs   (rd_occ),
        .thr   (empty_thr),
        .flag  (almost_empty)
    );

    afu_flag_cmp #(.LHS_W(OCC_W), .THR_W(ADDR_W), .RST_VAL(1'b0)) u_af (
        .clk   (wclk),
        .rst_n (flags_rst_n),
        .lhs   (free_space),
        .thr   (full_thr),
        .flag  (almost_full)
    );

endmodule

// File: rtl/afu_chk.sv
// Module: afu_chk
// Property checker bound into almost_flag_unit. It watches the ports and
// the threshold state that passes between the sub-blocks.
module afu_chk #(
    parameter int ADDR_W  = 17,
    parameter int PIECE_W = 9,
    parameter int SEQ_W   = 2
) (
    input logic                wclk,
    input logic                rclk,
    input logic                mrst_n,
    input logic                prst_n,
    input logic                ld,
    input logic                wen,
    input logic                sen,
    input logic                ren,
    input logic [ADDR_W:0]     rd_occ,
    input logic [ADDR_W:0]     wr_occ,
    input logic [PIECE_W-1:0]  dout,
    input logic                almost_empty,
    input logic                almost_full,
    input logic [ADDR_W-1:0]   empty_thr,
    input logic [ADDR_W-1:0]   full_thr,
    input logic                serial_mode,
    input logic [SEQ_W-1:0]    wseq
);

    localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1) << ADDR_W;

    // R8
    ae_follows_chk: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        1'b1 |=> (almost_empty == ($past(rd_occ) <= {1'b0, $past(empty_thr)})));

    // R9
    af_follows_chk: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        1'b1 |=> (almost_full == ((DEPTH_V - $past(wr_occ)) <= {1'b0, $past(full_thr)})));

    // R4
    thr_idle_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !(ld && (wen || sen)) |=> ($stable(empty_thr) && $stable(full_thr)));

    // R5
    serial_in_par_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        (!serial_mode && ld && sen && !wen) |=> ($stable(empty_thr) && $stable(full_thr)));

    // R3
    seq_wrap_chk: assert property (@(posedge wclk) disable iff (!mrst_n || !prst_n)
        (!serial_mode && ld && wen && wseq == SEQ_W'(2 * ((ADDR_W + PIECE_W - 1) / PIECE_W) - 1))
        |=> (wseq == '0));

    // R6
    dout_hold_chk: assert property (@(posedge rclk) disable iff (!mrst_n || !prst_n)
        !(ld && ren) |=> $stable(dout));

    // R7
    prst_keeps_chk: assert property (@(posedge wclk) disable iff (!mrst_n)
        !prst_n |=> ($stable(empty_thr) && $stable(full_thr) && $stable(serial_mode)));

endmodule

bind almost_flag_unit afu_chk #(
    .ADDR_W  (ADDR_W),
    .PIECE_W (PIECE_W),
    .SEQ_W   (SEQ_W)
) u_chk (
    .wclk         (wclk),
    .rclk         (rclk),
    .mrst_n       (mrst_n),
    .prst_n       (prst_n),
    .ld           (ld),
    .wen          (wen),
    .sen          (sen),
    .ren          (ren),
    .rd_occ       (rd_occ),
    .wr_occ       (wr_occ),
    .dout         (dout),
    .almost_empty (almost_empty),
    .almost_full  (almost_full),
    .empty_thr    (empty_thr),
    .full_thr     (full_thr),
    .serial_mode  (serial_mode),
    .wseq         (wseq)
);

// File: tb/tb_almost_flag_unit.sv
// Bench for almost_flag_unit: directed corner cases plus seeded random
// loads and occupancies, checked against a bench-side model.
module tb_almost_flag_unit;

    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = 16;
    localparam int AW   = 17;
    localparam int PW   = 9;
    localparam int NPC  = (AW + PW - 1) / PW;
    localparam int PADW = NPC * PW;
    localparam int NSEQ = 2 * NPC;
    localparam int SERB = 2 * AW;
    localparam int DEPTH = 1 << AW;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          mrst_n = 1'b0, prst_n = 1'b1;
    logic          ld = 1'b0, wen = 1'b0, sen = 1'b0, si = 1'b0, ren = 1'b0;
    logic [PW-1:0] din = '0;
    logic [AW:0]   rd_occ = '0, wr_occ = '0;
    logic [PW-1:0] dout;
    logic          almost_empty, almost_full;

    int checks = 0;
    int fails  = 0;

    // Bench model of the thresholds and pointers
    logic [AW-1:0] m_e, m_f;
    logic          m_ser;
    int            m_wseq, m_sbit, m_rseq;

    almost_flag_unit dut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .ld(ld), .wen(wen), .sen(sen), .si(si), .din(din), .ren(ren),
        .rd_occ(rd_occ), .wr_occ(wr_occ), .dout(dout),
        .almost_empty(almost_empty), .almost_full(almost_full)
    );

    always #(CLK_PERIOD/2)  wclk = ~wclk;
    always #(RCLK_PERIOD/2) rclk = ~rclk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [PW-1:0] exp_piece(input int idx);
        logic [PADW-1:0] p;
        p = (idx < NPC) ? PADW'(m_e) : PADW'(m_f);
        return p[(idx % NPC)*PW +: PW];
    endfunction

    task automatic do_mrst(input logic ldv);
        @(negedge wclk);
        mrst_n = 1'b0; ld = ldv;
        repeat (6) @(negedge wclk);
        mrst_n = 1'b1; ld = 1'b0;
        m_ser = ldv;
        m_e = ldv ? AW'(1023) : AW'(127);
        m_f = m_e;
        m_wseq = 0; m_sbit = 0; m_rseq = 0;
    endtask

    task automatic do_prst();
        @(negedge wclk);
        prst_n = 1'b0;
        repeat (6) @(negedge wclk);
        prst_n = 1'b1;
        m_wseq = 0; m_sbit = 0; m_rseq = 0;
    endtask

    task automatic par_write(input logic [PW-1:0] w);
        logic [PADW-1:0] p;
        @(negedge wclk);
        ld = 1'b1; wen = 1'b1; din = w;
        @(negedge wclk);
        ld = 1'b0; wen = 1'b0;
        if (!m_ser) begin
            p = (m_wseq < NPC) ? PADW'(m_e) : PADW'(m_f);
            p[(m_wseq % NPC)*PW +: PW] = w;
            if (m_wseq < NPC) m_e = p[AW-1:0]; else m_f = p[AW-1:0];
            m_wseq = (m_wseq + 1) % NSEQ;
        end
    endtask

    task automatic ser_bit(input logic b);
        @(negedge wclk);
        ld = 1'b1; sen = 1'b1; si = b;
        @(negedge wclk);
        ld = 1'b0; sen = 1'b0;
        if (m_ser && m_sbit < SERB) begin
            if (m_sbit < AW) m_e[m_sbit] = b; else m_f[m_sbit - AW] = b;
            m_sbit++;
        end
    endtask

    task automatic read_piece(input string req);
        logic [PW-1:0] e;
        @(negedge rclk);
        ld = 1'b1; ren = 1'b1;
        @(negedge rclk);
        ld = 1'b0; ren = 1'b0;
        e = exp_piece(m_rseq);
        m_rseq = (m_rseq + 1) % NSEQ;
        chk(req, 32'(dout), 32'(e));
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < NSEQ; i++) read_piece(req);
    endtask

    task automatic load_par(input logic [AW-1:0] e, input logic [AW-1:0] f);
        logic [PADW-1:0] p;
        p = PADW'(e);
        for (int k = 0; k < NPC; k++) par_write(p[k*PW +: PW]);
        p = PADW'(f);
        for (int k = 0; k < NPC; k++) par_write(p[k*PW +: PW]);
    endtask

    task automatic chk_ae(input int occ, input string req);
        @(negedge rclk);
        rd_occ = (AW+1)'(occ);
        @(negedge rclk);
        chk(req, 32'(almost_empty), 32'(occ <= int'(m_e)));
    endtask

    task automatic chk_af(input int occ, input string req);
        @(negedge wclk);
        wr_occ = (AW+1)'(occ);
        @(negedge wclk);
        chk(req, 32'(almost_full), 32'((DEPTH - occ) <= int'(m_f)));
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        #(CLK_PERIOD * 190000);
        fails++;
        $display("FAIL watchdog all-reqs actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int r;
        void'($urandom(32'd4242));

        // R1 defaults, and R10 reset values held during reset
        @(negedge wclk);
        mrst_n = 1'b0; ld = 1'b0;
        repeat (6) @(negedge wclk);
        chk("R10 ae in reset", 32'(almost_empty), 32'd1);
        chk("R10 af in reset", 32'(almost_full), 32'd0);
        chk("R10 dout in reset", 32'(dout), 32'd0);
        mrst_n = 1'b1;
        m_ser = 1'b0; m_e = AW'(127); m_f = AW'(127);
        m_wseq = 0; m_sbit = 0; m_rseq = 0;
        read_all("R1 default 127 readback");

        // R5: serial bits in parallel mode are ignored
        for (int i = 0; i < 5; i++) ser_bit(1'b1);
        read_all("R5 serial ignored in parallel mode");

        // R3: directed piece order, upper piece bit discarded
        par_write(9'h0A5); par_write(9'h1FF); par_write(9'h033); par_write(9'h101);
        read_all("R3 piece order and discard");
        // R3: fifth write wraps to slot 0
        par_write(9'h0C3);
        read_all("R3 wrap to slot 0");

        // R4: wen without ld, ld without wen
        @(negedge wclk); wen = 1'b1; din = 9'h000;
        @(negedge wclk); wen = 1'b0; ld = 1'b1;
        @(negedge wclk); ld = 1'b0;
        read_all("R4 unqualified write ignored");

        // R6: dout holds when ren alone is raised
        @(negedge rclk); ren = 1'b1;
        @(negedge rclk); ren = 1'b0;
        chk("R6 dout holds without ld", 32'(dout), 32'(exp_piece((m_rseq + NSEQ - 1) % NSEQ)));

        // R8 / R9 directed boundaries
        load_par(AW'(300), AW'(500));
        chk_ae(300, "R8 occ equal threshold");
        chk_ae(301, "R8 occ above threshold");
        chk_ae(0, "R8 occ zero");
        chk_af(DEPTH - 500, "R9 free equal threshold");
        chk_af(DEPTH - 501, "R9 free above threshold");
        chk_af(DEPTH, "R9 full");
        chk_af(0, "R9 empty fifo");

        // R7: partial reset mid-sequence keeps values, clears pointers
        par_write(9'h011);
        do_prst();
        chk("R10 ae after prst", 32'(almost_empty), 32'(0 <= int'(m_e)));
        par_write(9'h077);
        read_piece("R7 readback starts at slot 0");
        read_all("R7 values kept, pointer restarted");

        // R2: serial defaults; R4 parallel ignored in serial mode
        do_mrst(1'b1);
        read_all("R2 default 1023 readback");
        par_write(9'h155);
        read_all("R4 parallel ignored in serial mode");

        // R5: full serial load plus excess bits; R6 readback in serial mode
        for (int i = 0; i < SERB; i++) ser_bit(1'($urandom_range(0, 1)));
        for (int i = 0; i < 4; i++) ser_bit(~m_e[0]);
        read_all("R5/R6 serial load and excess ignored");

        // R7: partial reset mid-serial keeps mode and restarts bit 0
        ser_bit(1'b1); ser_bit(1'b0);
        do_prst();
        ser_bit(~m_e[0]);
        read_all("R7 serial restart at bit 0");

        // Random: parallel loads and occupancies near the thresholds
        do_mrst(1'b0);
        for (int it = 0; it < 40; it++) begin
            load_par(AW'($urandom_range(0, DEPTH - 1)), AW'($urandom_range(0, DEPTH - 1)));
            read_all("R3/R6 random readback");
            r = int'(m_e) + $urandom_range(0, 2) - 1;
            if (r < 0) r = 0;
            chk_ae(r, "R8 random");
            r = DEPTH - int'(m_f) + $urandom_range(0, 2) - 1;
            if (r > DEPTH) r = DEPTH;
            chk_af(r, "R9 random");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule